// File: doc/BRIEF.md
# Execute-Stage Arithmetic Unit with Operand Steering

This block is the execute step of a simple 32-bit single-cycle processor. On every clock cycle it takes the decoded instruction class (`opcode`), the function selector (`fn`) and three operand words: two register reads (`val_a`, `val_b`) and one constant from the instruction stream (`val_c`). It produces the result word `val_e`. The path from input to `val_e` is purely combinational, so the memory and write-back logic can use the result in the same cycle.

Two multiplexers in front of a single adder/logic unit pick the operands according to the instruction class. As a result, the same hardware computes register arithmetic, effective addresses, and stack-pointer adjustments by a fixed step. A three-bit condition register (zero, sign, overflow) captures the result flags on the clock edge. It does so only for arithmetic/logic instructions, so the flags that later branches test survive any other traffic.

Top module: `exe_stage`

## Requirements
- R1: Register move (opcode 2): `val_e` equals `val_a`.
- R2: Immediate move (opcode 3): `val_e` equals `val_c`.
- R3: Store (opcode 4) and load (opcode 5): `val_e` equals `val_b + val_c` modulo 2^32.
- R4: Call (opcode 8) and push (opcode 10) give `val_e = val_b - 4`. Return (opcode 9) and pop (opcode 11) give `val_e = val_b + 4`.
- R5: Arithmetic/logic operation (opcode 6) computes `val_b OP val_a`. The `fn` codes are 0 = add, 1 = subtract (`val_b - val_a`), 2 = bitwise AND and 3 = bitwise XOR. Any other `fn` code behaves as add.
- R6: Every other opcode (0 halt, 1 nop, 7 jump, 12 to 15 unassigned) passes `val_b` unchanged to `val_e`.
- R7: The flags `zf`, `sf` and `of` load on a rising clock edge only when `opcode` is 6 in that cycle. With any other opcode they hold their value.
- R8: After a load, `zf` is 1 exactly when the result was zero, and `sf` equals result bit 31.
- R9: After a load, `of` is 1 on two's-complement overflow of an add or subtract. It is 0 after an AND or XOR.
- R10: While `rst_n` is low, the flags read `zf = 1`, `sf = 0`, `of = 0`. This takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| opcode | input | 4 | Instruction class |
| fn | input | 4 | Function selector for opcode 6 |
| val_a | input | 32 | First register operand |
| val_b | input | 32 | Second register operand |
| val_c | input | 32 | Constant from the instruction |
| val_e | output | 32 | Execute result |
| zf | output | 1 | Registered zero flag |
| sf | output | 1 | Registered sign flag |
| of | output | 1 | Registered signed-overflow flag |

## Verification
The bench builds the block with its defaults: a 32-bit word and a stack step of 4. With a 32-bit word, the signed-overflow boundaries around 0x7FFFFFFF and 0x80000000 can be reached directly, including the case where adding two most-negative values wraps to zero. The step of 4 lets the bench drive stack-pointer wrap at zero in both directions. Rows that do not load the flags are placed right after rows that set unusual flag patterns, so hold behaviour is visible at the outputs.

// File: rtl/exe_pkg.sv
package exe_pkg;

  typedef enum logic [3:0] {
    OPC_HALT  = 4'd0,
    OPC_NOP   = 4'd1,
    OPC_RRMOV = 4'd2,
    OPC_IRMOV = 4'd3,
    OPC_STORE = 4'd4,
    OPC_LOAD  = 4'd5,
    OPC_ALU   = 4'd6,
    OPC_JUMP  = 4'd7,
    OPC_CALL  = 4'd8,
    OPC_RET   = 4'd9,
    OPC_PUSH  = 4'd10,
    OPC_POP   = 4'd11
  } opc_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } cc_t;

  localparam cc_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/exe_opsel.sv
module exe_opsel
  import exe_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int STEP  = 4
) (
  input  logic [3:0]       opcode,
  input  logic [3:0]       fn,
  input  logic [WIDTH-1:0] val_a,
  input  logic [WIDTH-1:0] val_b,
  input  logic [WIDTH-1:0] val_c,
  output logic [WIDTH-1:0] op_a,
  output logic [WIDTH-1:0] op_b,
  output alu_fn_e          alu_fn,
  output logic             cc_load
);

  localparam logic [WIDTH-1:0] STEP_UP   = WIDTH'(STEP);
  localparam logic [WIDTH-1:0] STEP_DOWN = -STEP_UP;

  // Operand A steering: register, constant, or stack step.
  always_comb begin
    op_a = '0;
    case (opcode)
      OPC_RRMOV, OPC_ALU:              op_a = val_a;
      OPC_IRMOV, OPC_STORE, OPC_LOAD:  op_a = val_c;
      OPC_CALL, OPC_PUSH:              op_a = STEP_DOWN;
      OPC_RET, OPC_POP:                op_a = STEP_UP;
      default:                         op_a = '0;
    endcase
  end

  // Operand B steering: moves bypass the register operand.
  always_comb begin
    case (opcode)
      OPC_RRMOV, OPC_IRMOV: op_b = '0;
      default:              op_b = val_b;
    endcase
  end

  // Function select: only opcode 6 reaches past the adder.
  always_comb begin
    alu_fn  = FN_ADD;
    cc_load = 1'b0;
    if (opcode == OPC_ALU) begin
      cc_load = 1'b1;
      case (fn)
        4'd1:    alu_fn = FN_SUB;
        4'd2:    alu_fn = FN_AND;
        4'd3:    alu_fn = FN_XOR;
        default: alu_fn = FN_ADD;
      endcase
    end
  end

endmodule

// File: rtl/exe_alu.sv
module exe_alu
  import exe_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  alu_fn_e          alu_fn,
  output logic [WIDTH-1:0] result,
  output cc_t              flags
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] diff;
  logic             ovf_add;
  logic             ovf_sub;

  always_comb begin
    sum     = op_b + op_a;
    diff    = op_b - op_a;
    ovf_add = (op_a[MSB] == op_b[MSB]) && (sum[MSB]  != op_b[MSB]);
    ovf_sub = (op_a[MSB] != op_b[MSB]) && (diff[MSB] != op_b[MSB]);
  end

  always_comb begin
    flags.of = 1'b0;
    case (alu_fn)
      FN_SUB:  begin result = diff; flags.of = ovf_sub; end
      FN_AND:  result = op_b & op_a;
      FN_XOR:  result = op_b ^ op_a;
      default: begin result = sum; flags.of = ovf_add; end
    endcase
    flags.zf = (result == '0);
    flags.sf = result[MSB];
  end

endmodule

// File: rtl/exe_ccreg.sv
module exe_ccreg
  import exe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cc_t  cc_next,
  output cc_t  cc_q
);

  cc_t cc_d;

  always_comb begin
    cc_d = cc_q;
    if (load) cc_d = cc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_q <= CC_RESET;
    else        cc_q <= cc_d;
  end

endmodule

// File: rtl/exe_stage.sv
module exe_stage
  import exe_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       opcode,
  input  logic [3:0]       fn,
  input  logic [WIDTH-1:0] val_a,
  input  logic [WIDTH-1:0] val_b,
  input  logic [WIDTH-1:0] val_c,
  output logic [WIDTH-1:0] val_e,
  output logic             zf,
  output logic             sf,
  output logic             of
);

  logic [WIDTH-1:0] op_a;
  logic [WIDTH-1:0] op_b;
  alu_fn_e          alu_fn;
  logic             cc_load;
  cc_t              alu_flags;
  cc_t              cc_q;

  exe_opsel #(.WIDTH(WIDTH), .STEP(STEP)) u_opsel (
    .opcode (opcode),
    .fn     (fn),
    .val_a  (val_a),
    .val_b  (val_b),
    .val_c  (val_c),
    .op_a   (op_a),
    .op_b   (op_b),
    .alu_fn (alu_fn),
    .cc_load(cc_load)
  );

  exe_alu #(.WIDTH(WIDTH)) u_alu (
    .op_a  (op_a),
    .op_b  (op_b),
    .alu_fn(alu_fn),
    .result(val_e),
    .flags (alu_flags)
  );

  exe_ccreg u_cc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cc_load),
    .cc_next(alu_flags),
    .cc_q   (cc_q)
  );

  assign zf = cc_q.zf;
  assign sf = cc_q.sf;
  assign of = cc_q.of;

endmodule

// File: rtl/exe_stage_chk.sv
module exe_stage_chk #(
  parameter int WIDTH = 32,
  parameter int STEP  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       opcode,
  input logic [3:0]       fn,
  input logic [WIDTH-1:0] val_a,
  input logic [WIDTH-1:0] val_b,
  input logic [WIDTH-1:0] val_c,
  input logic [WIDTH-1:0] val_e,
  input logic             zf,
  input logic             sf,
  input logic             of
);

  localparam logic [WIDTH-1:0] STEP_W = WIDTH'(STEP);

  a_r1_reg_move: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 4'd2) |-> (val_e == val_a));

  a_r3_eff_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 4'd4 || opcode == 4'd5) |-> (val_e == val_b + val_c));

  a_r4_stack_down: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 4'd8 || opcode == 4'd10) |-> (val_e == val_b - STEP_W));

  a_r4_stack_up: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 4'd9 || opcode == 4'd11) |-> (val_e == val_b + STEP_W));

  a_r7_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode != 4'd6) |=> $stable({zf, sf, of}));

  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 4'd6) |=> (zf == ($past(val_e) == '0)));

  a_r8_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 4'd6) |=> (sf == $past(val_e[WIDTH-1])));

  a_r9_logic_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 4'd6 && (fn == 4'd2 || fn == 4'd3)) |=> !of);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_flags: assert (zf && !sf && !of);
    end
  end

endmodule

bind exe_stage exe_stage_chk #(.WIDTH(WIDTH), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .fn(fn),
  .val_a(val_a), .val_b(val_b), .val_c(val_c),
  .val_e(val_e), .zf(zf), .sf(sf), .of(of)
);

// File: tb/tb_exe_stage.sv
module tb_exe_stage;

  localparam int NVEC = 18;

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic [3:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    logic [31:0] e;
    logic [2:0]  fl;   // {zf, sf, of}, used only for opcode 6
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{4'd1,  4'd2,  4'd0, 32'h0000_1234, 32'h0000_0999, 32'h0, 32'h0000_1234, 3'b000}, // R1
    '{4'd2,  4'd3,  4'd0, 32'h0,         32'h0000_0005, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b000}, // R2
    '{4'd3,  4'd4,  4'd0, 32'h0,         32'h0000_0100, 32'h0000_0020, 32'h0000_0120, 3'b000}, // R3
    '{4'd3,  4'd5,  4'd0, 32'h0,         32'hFFFF_FFF0, 32'h0000_0014, 32'h0000_0004, 3'b000}, // R3 wrap
    '{4'd4,  4'd8,  4'd0, 32'h0,         32'h0000_1000, 32'h0, 32'h0000_0FFC, 3'b000}, // R4 call
    '{4'd4,  4'd10, 4'd0, 32'h0,         32'h0000_0002, 32'h0, 32'hFFFF_FFFE, 3'b000}, // R4 push wrap
    '{4'd4,  4'd9,  4'd0, 32'h0,         32'h0000_0FFC, 32'h0, 32'h0000_1000, 3'b000}, // R4 ret
    '{4'd4,  4'd11, 4'd0, 32'h0,         32'hFFFF_FFFC, 32'h0, 32'h0000_0000, 3'b000}, // R4 pop wrap
    '{4'd5,  4'd6,  4'd0, 32'h0000_0001, 32'h0000_0002, 32'h0, 32'h0000_0003, 3'b000}, // R5 add
    '{4'd9,  4'd6,  4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0, 32'h8000_0000, 3'b011}, // R9 add ovf
    '{4'd8,  4'd6,  4'd1, 32'h0000_0005, 32'h0000_0005, 32'h0, 32'h0000_0000, 3'b100}, // R8 sub zero
    '{4'd9,  4'd6,  4'd1, 32'h0000_0001, 32'h8000_0000, 32'h0, 32'h7FFF_FFFF, 3'b001}, // R9 sub ovf
    '{4'd5,  4'd6,  4'd2, 32'h0000_F0F0, 32'h0000_0FF0, 32'h0, 32'h0000_00F0, 3'b000}, // R5 and
    '{4'd5,  4'd6,  4'd3, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 32'hFFFF_FFFE, 3'b010}, // R5 xor
    '{4'd6,  4'd7,  4'd0, 32'h0000_0009, 32'h0000_0055, 32'h0, 32'h0000_0055, 3'b000}, // R6 jump, R7 hold
    '{4'd5,  4'd6,  4'd9, 32'h0000_0003, 32'h0000_0004, 32'h0, 32'h0000_0007, 3'b000}, // R5 unassigned fn
    '{4'd9,  4'd6,  4'd0, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0000_0000, 3'b101}, // R9 R8 add wraps to 0
    '{4'd7,  4'd1,  4'd0, 32'h0000_0001, 32'h0000_0007, 32'h0, 32'h0000_0007, 3'b000}  // R7 nop hold
  };

  logic        clk;
  logic        rst_n;
  logic [3:0]  opcode;
  logic [3:0]  fn;
  logic [31:0] val_a, val_b, val_c, val_e;
  logic        zf, sf, of;

  int n_checks = 0;
  int n_errors = 0;
  logic [2:0] exp_fl;

  exe_stage dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .fn(fn),
    .val_a(val_a), .val_b(val_b), .val_c(val_c),
    .val_e(val_e), .zf(zf), .sf(sf), .of(of)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b1; opcode = 4'd1; fn = 4'd0;
    val_a = '0; val_b = '0; val_c = '0;
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #2 check("R10 reset flags", {29'd0, zf, sf, of}, 32'b100);
    @(negedge clk) rst_n = 1'b1;
    exp_fl = 3'b100;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      opcode = VEC[i].op; fn = VEC[i].fn;
      val_a = VEC[i].a; val_b = VEC[i].b; val_c = VEC[i].c;
      #2 check($sformatf("R%0d row %0d val_e", VEC[i].req, i), val_e, VEC[i].e);
      if (VEC[i].op == 4'd6) exp_fl = VEC[i].fl;
      @(posedge clk);
      #2 check($sformatf("R%0d row %0d flags", VEC[i].req, i), {29'd0, zf, sf, of}, {29'd0, exp_fl});
    end

    // R7: halt and an unassigned opcode leave flags {1,0,1}; R6 passes val_b
    @(negedge clk);
    opcode = 4'd0; val_a = 32'h1; val_b = 32'h8000_0000;
    #2 check("R6 halt passes val_b", val_e, 32'h8000_0000);
    @(negedge clk);
    opcode = 4'd15; val_b = 32'h0;
    #2 check("R6 opcode 15 passes val_b", val_e, 32'h0);
    @(posedge clk);
    #2 check("R7 flags held over halt/unused", {29'd0, zf, sf, of}, 32'b101);

    // R8: negative non-zero sub result sets only sf
    @(negedge clk);
    opcode = 4'd6; fn = 4'd1; val_a = 32'h3; val_b = 32'h1;
    #2 check("R5 sub 1-3", val_e, 32'hFFFF_FFFE);
    @(posedge clk);
    #2 check("R8 sf after negative sub", {29'd0, zf, sf, of}, 32'b010);

    // R10: asynchronous reset between edges
    @(negedge clk);
    opcode = 4'd1;
    #3 rst_n = 1'b0;
    #1 check("R10 async reset flags", {29'd0, zf, sf, of}, 32'b100);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #2 check("R10 flags after release", {29'd0, zf, sf, of}, 32'b100);

    finish_run();
  end

endmodule